// File: doc/BRIEF.md
# Two-Bin Paced Transmit Queue Scheduler

This block decides which of several transmit queues may send its next packet. Every queue has its own pace setting. A setting of zero places the queue in the fast bin. Any other setting places it in the paced bin. In the paced bin, the block holds the queue back for a programmed number of base ticks after each grant. Each bin keeps its own round-robin pointer. When both bins hold an eligible queue, the grants alternate between the bins one packet at a time. As a result, a lone fast queue that always has work receives half of all grants, however many paced queues are busy.

Pace settings and a bin threshold are written through a small configuration port. Settings of 21 and above are a special code: the queue stays in the paced bin but has no delay. A queue whose setting is above the threshold is parked and receives no grants. The comparison counts every special-code setting as 21, so a threshold of 21 parks nothing. A grant stays up until the downstream logic signals that the packet is finished. Only then can the next grant be issued.

Top module: `pace_bin_sched`

## Requirements
- R1: During and after reset, `gnt_valid` is low and `gnt_onehot` is zero. Reset leaves every pace setting at 0 and the threshold at 21. Both round-robin pointers start so that queue 0 is searched first, and the fast bin wins the first contest between the bins.
- R2: A queue whose pace setting is 0 is in the fast bin. Eligible fast-bin queues are granted in ascending index order, wrapping around, starting after the last fast-bin queue served.
- R3: A queue whose pace setting is nonzero and not parked is in the paced bin. Eligible paced-bin queues are granted in ascending index order, wrapping around, starting after the last paced-bin queue served.
- R4: When both bins hold an eligible queue, the bin that was not used for the previous grant is chosen. When only one bin has an eligible queue, that bin takes the slot.
- R5: A paced queue with setting p in 1..20 is granted, and the done strobe is held high. The next grant to that same queue (when it is the only requester) comes max(2, p·TICK+1) clock cycles later.
- R6: A pace setting in 21..31 keeps the queue in the paced bin with no delay. Back-to-back grants to that queue are 2 cycles apart.
- R7: A queue is parked and never granted when its level (its setting, with any value of 21 or more counted as 21) is greater than the threshold. The threshold is written by `cfg_we` with `cfg_thr_sel`=1.
- R8: Once raised, `gnt_valid` and `gnt_idx` hold steady until a cycle where `pkt_done` is high. On the next edge `gnt_valid` falls. A new grant can rise no earlier than the edge after that.
- R9: A grant is issued only to a queue whose `q_work` bit was high at the issuing edge. With no eligible queue, `gnt_valid` stays low.
- R10: Take one fast queue with work and all other queues in the paced bin with zero delay and work. The fast queue then receives exactly every other grant.
- R11: While `gnt_valid` is high, `gnt_onehot` has exactly bit `gnt_idx` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_work | input | NQ | Per-queue flag: the queue has a packet waiting |
| pkt_done | input | 1 | The packet of the current grant has finished |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr_sel | input | 1 | 1: the write goes to the threshold; 0: it goes to the pace setting of queue `cfg_idx` |
| cfg_idx | input | $clog2(NQ) | Queue index of a pace write |
| cfg_data | input | PACE_W | Write data |
| gnt_valid | output | 1 | A grant is outstanding |
| gnt_idx | output | $clog2(NQ) | Index of the granted queue |
| gnt_onehot | output | NQ | One-hot form of the grant; zero when idle |

## Verification
The bench builds the block with four queues and a base tick of two cycles. This configuration is small enough to sweep every non-empty work mask through both bins. It also allows a pass of the fast-bin-versus-paced-bin pattern with each queue acting as the fast one. With a two-cycle tick, the delay for each pace setting from 1 to 6 differs from the floor of two cycles and from its neighbours. That means an error in the reload value or in the counter shows up as a measurable change in the spacing between grants.

// File: rtl/pace_bin_sched_pkg.sv
package pace_bin_sched_pkg;
   // Pace code from which a queue is delay-free but stays in the paced bin
   localparam int SPECIAL_PACE = 21;
   localparam int MAX_DELAY_PACE = SPECIAL_PACE - 1;

   typedef enum logic {
      BIN_FAST  = 1'b0,
      BIN_PACED = 1'b1
   } bin_e;
endpackage

// File: rtl/pace_slot.sv
module pace_slot
   import pace_bin_sched_pkg::*;
#(
   parameter int PACE_W = 5,
   parameter int TICK   = 2,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PACE_W-1:0] wr_data,
   input  logic [PACE_W-1:0] thr,
   input  logic              work,
   input  logic              load,
   output logic              req_fast,
   output logic              req_paced
);
   localparam logic [PACE_W-1:0] SPECIAL = PACE_W'(SPECIAL_PACE);

   logic [PACE_W-1:0] pace_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PACE_W-1:0] level;
   logic              parked;
   logic              no_delay;
   logic [CNT_W-1:0]  reload;

   always_comb begin
      level     = (pace_q >= SPECIAL) ? SPECIAL : pace_q;
      parked    = level > thr;
      no_delay  = (pace_q == '0) || (pace_q >= SPECIAL);
      reload    = no_delay ? '0 : CNT_W'(pace_q) * CNT_W'(TICK);
      req_fast  = work && (pace_q == '0);
      req_paced = work && (pace_q != '0) && !parked && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pace_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) pace_q <= wr_data;
         if (load) cnt_q <= reload;
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int NQ = 4,
   parameter int IW = 2
) (
   input  logic [NQ-1:0] req,
   input  logic [IW-1:0] last,
   output logic          hit,
   output logic [IW-1:0] pick
);
   always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int k = 1; k <= NQ; k++) begin
         if (!hit && req[(int'(last) + k) % NQ]) begin
            hit  = 1'b1;
            pick = IW'((int'(last) + k) % NQ);
         end
      end
   end
endmodule

// File: rtl/pace_bin_sched.sv
module pace_bin_sched
   import pace_bin_sched_pkg::*;
#(
   parameter int NQ     = 4,
   parameter int PACE_W = 5,
   parameter int TICK   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NQ-1:0]         q_work,
   input  logic                  pkt_done,
   input  logic                  cfg_we,
   input  logic                  cfg_thr_sel,
   input  logic [$clog2(NQ)-1:0] cfg_idx,
   input  logic [PACE_W-1:0]     cfg_data,
   output logic                  gnt_valid,
   output logic [$clog2(NQ)-1:0] gnt_idx,
   output logic [NQ-1:0]         gnt_onehot
);
   localparam int IW    = $clog2(NQ);
   localparam int CNT_W = $clog2(MAX_DELAY_PACE * TICK + 1);
   localparam logic [IW-1:0] LAST_INIT = IW'(NQ - 1);

   if (NQ < 2 || (1 << IW) != NQ) begin : g_bad_nq
      $error("NQ must be a power of two, at least 2");
   end
   if (TICK < 1) begin : g_bad_tick
      $error("TICK must be at least 1");
   end
   if ((1 << PACE_W) <= SPECIAL_PACE) begin : g_bad_pace_w
      $error("PACE_W too narrow for the special pace code");
   end

   logic [PACE_W-1:0] thr_q;
   logic [NQ-1:0]     req_bin [2];
   logic [IW-1:0]     last_q  [2];
   logic              hit_b   [2];
   logic [IW-1:0]     pick_b  [2];
   logic              fav_fast_q;
   logic              gnt_valid_q;
   logic [IW-1:0]     gnt_idx_q;
   bin_e              take;
   logic              issue;
   logic [IW-1:0]     sel;

   for (genvar i = 0; i < NQ; i++) begin : g_slot
      pace_slot #(.PACE_W(PACE_W), .TICK(TICK), .CNT_W(CNT_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && !cfg_thr_sel && (cfg_idx == IW'(i))),
         .wr_data  (cfg_data),
         .thr      (thr_q),
         .work     (q_work[i]),
         .load     (issue && (sel == IW'(i))),
         .req_fast (req_bin[0][i]),
         .req_paced(req_bin[1][i])
      );
   end

   for (genvar b = 0; b < 2; b++) begin : g_bin
      rr_pick #(.NQ(NQ), .IW(IW)) u_rr (
         .req (req_bin[b]),
         .last(last_q[b]),
         .hit (hit_b[b]),
         .pick(pick_b[b])
      );
   end

   always_comb begin
      take  = (hit_b[1] && (!hit_b[0] || !fav_fast_q)) ? BIN_PACED : BIN_FAST;
      sel   = (take == BIN_PACED) ? pick_b[1] : pick_b[0];
      issue = !gnt_valid_q && (hit_b[0] || hit_b[1]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q       <= PACE_W'(SPECIAL_PACE);
         last_q[0]   <= LAST_INIT;
         last_q[1]   <= LAST_INIT;
         fav_fast_q  <= 1'b1;
         gnt_valid_q <= 1'b0;
         gnt_idx_q   <= '0;
      end else begin
         if (cfg_we && cfg_thr_sel) thr_q <= cfg_data;
         if (issue) begin
            gnt_valid_q  <= 1'b1;
            gnt_idx_q    <= sel;
            last_q[take] <= sel;
            fav_fast_q   <= (take == BIN_PACED);
         end else if (gnt_valid_q && pkt_done) begin
            gnt_valid_q <= 1'b0;
         end
      end
   end

   assign gnt_valid  = gnt_valid_q;
   assign gnt_idx    = gnt_idx_q;
   assign gnt_onehot = gnt_valid_q ? (NQ'(1) << gnt_idx_q) : '0;
endmodule

// File: rtl/pace_bin_sched_chk.sv
module pace_bin_sched_chk #(
   parameter int NQ = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NQ-1:0]         q_work,
   input logic                  pkt_done,
   input logic                  gnt_valid,
   input logic [$clog2(NQ)-1:0] gnt_idx,
   input logic [NQ-1:0]         gnt_onehot
);
   logic [NQ-1:0] work_d;

   always_ff @(posedge clk) begin
      if (!rst_n) work_d <= '0;
      else        work_d <= q_work;
   end

   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !gnt_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid && !pkt_done |=> gnt_valid && $stable(gnt_idx));

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid && pkt_done |=> !gnt_valid);

   p_has_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> work_d[gnt_idx]);

   p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> $onehot(gnt_onehot) && gnt_onehot[gnt_idx]);

   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_valid |-> gnt_onehot == '0);
endmodule

bind pace_bin_sched pace_bin_sched_chk #(.NQ(NQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .q_work    (q_work),
   .pkt_done  (pkt_done),
   .gnt_valid (gnt_valid),
   .gnt_idx   (gnt_idx),
   .gnt_onehot(gnt_onehot)
);

// File: tb/pace_bin_sched_bench.sv
module pace_bin_sched_bench;
   localparam int NQ = 4;
   localparam int PW = 5;
   localparam int TK = 2;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NQ-1:0] q_work = '0;
   logic          pkt_done = 1'b1;
   logic          cfg_we = 1'b0;
   logic          cfg_thr_sel = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [PW-1:0] cfg_data = '0;
   logic          gnt_valid;
   logic [IW-1:0] gnt_idx;
   logic [NQ-1:0] gnt_onehot;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   pace_bin_sched #(.NQ(NQ), .PACE_W(PW), .TICK(TK)) u_pace_bin_sched (
      .clk(clk), .rst_n(rst_n), .q_work(q_work), .pkt_done(pkt_done),
      .cfg_we(cfg_we), .cfg_thr_sel(cfg_thr_sel), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
      .gnt_onehot(gnt_onehot));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; q_work = '0; pkt_done = 1'b1; cfg_we = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic wr(input bit thr, input int idx, input int val);
      cfg_we = 1'b1; cfg_thr_sel = thr; cfg_idx = IW'(idx); cfg_data = PW'(val);
      step();
      cfg_we = 1'b0;
   endtask

   task automatic grab(input int n, input int limit, output int seq[16],
                       output int at[16], output int got);
      got = 0;
      for (int t = 0; t < limit && got < n; t++) begin
         step();
         if (gnt_valid) begin
            seq[got] = int'(gnt_idx);
            at[got]  = cyc;
            got++;
            check(gnt_onehot == (NQ'(1) << gnt_idx), "R11 onehot", int'(gnt_onehot),
                  1 << int'(gnt_idx));
         end
      end
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int seq[16];
      int at[16];
      int got;
      int exp;
      int p;
      int nu;

      // R1: idle during and after reset
      rst_n = 1'b0;
      step(); step();
      check(!gnt_valid, "R1 in reset", int'(gnt_valid), 0);
      do_reset();
      check(!gnt_valid && gnt_onehot == '0, "R1 after reset", int'(gnt_valid), 0);

      // R2 / R3 / R6: round-robin sweep over all masks in each bin
      for (int bin = 0; bin < 2; bin++) begin
         for (int m = 1; m < 16; m++) begin
            do_reset();
            if (bin == 1) for (int q = 0; q < NQ; q++) wr(0, q, 21 + 3 * q);
            q_work = NQ'(m);
            grab(8, 40, seq, at, got);
            check(got == 8, bin == 0 ? "R2 count" : "R3 count", got, 8);
            p = NQ - 1;
            for (int g = 0; g < got; g++) begin
               for (int k = 1; k <= NQ; k++) begin
                  if (m[(p + k) % NQ]) begin exp = (p + k) % NQ; break; end
               end
               p = exp;
               check(seq[g] == exp, bin == 0 ? "R2 order" : "R3 order", seq[g], exp);
               if (g > 0) check(at[g] - at[g-1] == 2, "R6 spacing", at[g] - at[g-1], 2);
            end
            q_work = '0;
         end
      end

      // R4 / R10: one fast queue against busy delay-free paced queues
      for (int u = 0; u < NQ; u++) begin
         do_reset();
         for (int q = 0; q < NQ; q++) if (q != u) wr(0, q, 21 + 2 * q);
         q_work = '1;
         grab(12, 60, seq, at, got);
         nu = 0;
         p = NQ - 1;
         for (int g = 0; g < got; g++) begin
            if (g % 2 == 0) exp = u;
            else begin
               for (int k = 1; k <= NQ; k++) begin
                  if ((p + k) % NQ != u) begin exp = (p + k) % NQ; break; end
               end
               p = exp;
            end
            if (seq[g] == u) nu++;
            check(seq[g] == exp, "R4 alternation", seq[g], exp);
         end
         check(nu == 6 && got == 12, "R10 half share", nu, 6);
         q_work = '0;
      end

      // R4: paced queue on delay, fast bin takes every slot
      do_reset();
      wr(0, 1, 10);
      q_work = 4'b0011;
      grab(6, 40, seq, at, got);
      check(seq[0] == 0 && seq[1] == 1, "R4 first pair", seq[1], 1);
      for (int g = 2; g < 6; g++) check(seq[g] == 0, "R4 single bin", seq[g], 0);
      q_work = '0;

      // R5 / R6: spacing of a lone paced queue
      for (int pv = 1; pv <= 9; pv++) begin
         int pace;
         int gap;
         pace = (pv <= 6) ? pv : 21 + 5 * (pv - 7);
         gap  = (pace >= 21) ? 2 : ((pace * TK + 1 > 2) ? pace * TK + 1 : 2);
         do_reset();
         wr(0, 2, pace);
         q_work = 4'b0100;
         grab(3, 80, seq, at, got);
         check(got == 3, "R5 count", got, 3);
         check(at[1] - at[0] == gap, pace >= 21 ? "R6 gap" : "R5 gap", at[1] - at[0], gap);
         check(at[2] - at[1] == gap, pace >= 21 ? "R6 gap" : "R5 gap", at[2] - at[1], gap);
         q_work = '0;
      end

      // R7: threshold parking
      do_reset();
      wr(1, 0, 5);
      wr(0, 3, 6);
      q_work = 4'b1000;
      grab(1, 40, seq, at, got);
      check(got == 0, "R7 pace above threshold parked", got, 0);
      q_work = '0;
      wr(0, 3, 5);
      q_work = 4'b1000;
      grab(1, 40, seq, at, got);
      check(got == 1 && seq[0] == 3, "R7 pace at threshold granted", got, 1);
      q_work = '0;
      step(); step();
      wr(0, 3, 23);
      q_work = 4'b1000;
      grab(1, 40, seq, at, got);
      check(got == 0, "R7 special code parked under low threshold", got, 0);
      q_work = '0;
      wr(1, 0, 21);
      q_work = 4'b1000;
      grab(1, 40, seq, at, got);
      check(got == 1, "R7 threshold 21 releases", got, 1);
      q_work = '0;

      // R9: no work, no grant
      do_reset();
      grab(1, 30, seq, at, got);
      check(got == 0, "R9 idle", got, 0);

      // R8: grant held until done
      do_reset();
      pkt_done = 1'b0;
      q_work = 4'b0011;
      step();
      check(gnt_valid && gnt_idx == 0, "R8 first grant", int'(gnt_idx), 0);
      for (int t = 0; t < 10; t++) begin
         step();
         check(gnt_valid && gnt_idx == 0, "R8 hold", int'(gnt_valid), 1);
      end
      pkt_done = 1'b1;
      step();
      check(!gnt_valid, "R8 release", int'(gnt_valid), 0);
      step();
      check(gnt_valid && gnt_idx == 1, "R8 next grant", int'(gnt_idx), 1);
      q_work = '0;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule